// File: doc/BRIEF.md
# Configurable Digital Input Noise Canceller

This block cleans up asynchronous digital inputs, such as external interrupt pins or a serial receive line, before they reach the logic that uses them. Each input is first brought into the clock domain through a two-stage synchronizer. A filtered copy of the level then changes only after the synchronized input has stayed at the new value for a full reject threshold of consecutive clocks. When the filtered level changes in the direction the channel watches, the block raises a request output for exactly one clock. Interrupt latching and priority are left to the logic downstream.

There are three kinds of channel. The fixed channels (two by default) use a constant threshold and request only on a falling edge. The selectable channel takes its threshold from a 1-bit select and its edge direction from a separate bit. The receive channel takes a 2-bit mode that either bypasses the filter or picks one of three thresholds, and it requests on a falling edge, which is where a start bit begins. All filtered levels sit high out of reset, which is the idle state of the inputs. A threshold select is sampled into the channel every clock, so a new setting governs the filter from the next clock onward, well inside the 64-clock limit.

Top module: `glitch_canceller`

## Requirements
- R1: Once reset is released, every filtered level output is 1 and every request output is 0.
- R2: A fixed channel has a reject threshold of 4 clocks. An input pulse held for fewer than 4 clocks (and so every pulse under 2 clocks) leaves its filtered level unchanged. A pulse held for 4 clocks or more (and so every pulse of 7 clocks or more) is passed to the filtered level.
- R3: If the synchronized input goes back to the filtered level before the threshold is reached, the count of consecutive clocks starts over. Two 3-clock low pulses split by a 1-clock high gap are therefore both rejected on a fixed channel.
- R4: A fixed channel raises a request only when its filtered level falls. A rising filtered level never raises a request.
- R5: On the selectable channel, `sel_short`=0 sets a threshold of 63 clocks and `sel_short`=1 sets a threshold of 15 clocks. A pulse held for at least the threshold passes, and a pulse one clock shorter is rejected.
- R6: On the selectable channel, `sel_fall`=0 raises the request when the filtered level rises, and `sel_fall`=1 raises it when the filtered level falls.
- R7: The receive channel decodes `rx_mode` as follows: 0 means no rejection (a 1-clock threshold), 1 means 31 clocks, 2 means 63 clocks and 3 means 127 clocks. It raises its request on a falling filtered level.
- R8: While a channel's enable is 0, a committed level change raises no request. The filtered level still follows the input.
- R9: A change of threshold select governs the filter from the clock after the change, which is within 64 clocks.
- R10: A request lasts exactly one clock and appears only when the filtered level changes. If an input change is first set up before clock edge c+1 and its threshold is T, the filtered level and the request change at edge c+T+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fix_pin | input | NFIX | Raw inputs of the fixed-threshold channels |
| fix_en | input | NFIX | Request enables of the fixed channels |
| fix_level | output | NFIX | Filtered levels of the fixed channels |
| fix_req | output | NFIX | One-clock falling-edge requests of the fixed channels |
| sel_pin | input | 1 | Raw input of the selectable channel |
| sel_en | input | 1 | Request enable of the selectable channel |
| sel_fall | input | 1 | Edge select: 0 rising, 1 falling |
| sel_short | input | 1 | Threshold select: 0 gives 63 clocks, 1 gives 15 clocks |
| sel_level | output | 1 | Filtered level of the selectable channel |
| sel_req | output | 1 | One-clock edge request of the selectable channel |
| rx_pin | input | 1 | Raw serial receive input |
| rx_en | input | 1 | Request enable of the receive channel |
| rx_mode | input | 2 | Receive threshold: 0 bypass, 1 gives 31, 2 gives 63, 3 gives 127 clocks |
| rx_level | output | 1 | Filtered receive level |
| rx_req | output | 1 | One-clock falling-edge request of the receive channel |

## Verification
The hardest cases to reach are the ones at the exact threshold boundary. A pulse of T-1 clocks must vanish, while a pulse of T clocks must produce a level change and a request at one precise clock. The difference is a single clock of pulse width, and it has to be shown for every threshold value. The stimulus drives pulses from the clock edge opposite the sampling edge, so that each pulse lasts a whole number of clocks. Pairs of pulses one clock apart in width are then applied to each threshold, including just after a mode change. The fragmented-pulse pattern is built by hand so that the count-restart rule is exercised separately from plain rejection.

// File: rtl/nc_pkg.sv
package nc_pkg;
  localparam int CW        = 8;
  localparam int FIX_THR   = 4;
  localparam int SEL_LONG  = 63;
  localparam int SEL_SHORT = 15;
  localparam int RX_THR1   = 31;
  localparam int RX_THR2   = 63;
  localparam int RX_THR3   = 127;

  function automatic logic [CW-1:0] sel_threshold(input logic short_sel);
    return short_sel ? CW'(SEL_SHORT) : CW'(SEL_LONG);
  endfunction

  function automatic logic [CW-1:0] rx_threshold(input logic [1:0] mode);
    case (mode)
      2'd0:    return CW'(1);
      2'd1:    return CW'(RX_THR1);
      2'd2:    return CW'(RX_THR2);
      default: return CW'(RX_THR3);
    endcase
  endfunction
endpackage

// File: rtl/nc_sync.sv
module nc_sync #(
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_LVL;
      q    <= RST_LVL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/nc_filter.sv
module nc_filter #(
  parameter int            CW      = 8,
  parameter logic          RST_LVL = 1'b1,
  parameter logic [CW-1:0] THR_RST = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [CW-1:0] thr,
  output logic          level,
  output logic          commit
);
  logic [CW-1:0] thr_q;
  logic [CW-1:0] cnt;
  logic [CW:0]   cnt_next;

  assign cnt_next = {1'b0, cnt} + 1'b1;
  assign commit   = (din != level) && (cnt_next >= {1'b0, thr_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= THR_RST;
      cnt   <= '0;
      level <= RST_LVL;
    end else begin
      thr_q <= thr;
      if (din == level) begin
        cnt <= '0;
      end else if (commit) begin
        level <= din;
        cnt   <= '0;
      end else begin
        cnt <= cnt_next[CW-1:0];
      end
    end
  end
endmodule

// File: rtl/nc_edge.sv
module nc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fall,
  input  logic commit,
  input  logic new_level,
  output logic req
);
  logic hit;
  assign hit = commit && (fall ? !new_level : new_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= en && hit;
  end
endmodule

// File: rtl/nc_channel.sv
module nc_channel #(
  parameter int            CW      = 8,
  parameter logic          RST_LVL = 1'b1,
  parameter logic [CW-1:0] THR_RST = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  logic          en,
  input  logic          fall,
  input  logic [CW-1:0] thr,
  output logic          sync,
  output logic          level,
  output logic          req
);
  logic commit;

  nc_sync #(.RST_LVL(RST_LVL)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin), .q(sync)
  );

  nc_filter #(.CW(CW), .RST_LVL(RST_LVL), .THR_RST(THR_RST)) u_filt (
    .clk(clk), .rst_n(rst_n), .din(sync), .thr(thr),
    .level(level), .commit(commit)
  );

  nc_edge u_edge (
    .clk(clk), .rst_n(rst_n), .en(en), .fall(fall),
    .commit(commit), .new_level(sync), .req(req)
  );
endmodule

// File: rtl/glitch_canceller.sv
module glitch_canceller
  import nc_pkg::*;
#(
  parameter int   NFIX    = 2,
  parameter logic RST_LVL = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NFIX-1:0] fix_pin,
  input  logic [NFIX-1:0] fix_en,
  output logic [NFIX-1:0] fix_level,
  output logic [NFIX-1:0] fix_req,
  input  logic            sel_pin,
  input  logic            sel_en,
  input  logic            sel_fall,
  input  logic            sel_short,
  output logic            sel_level,
  output logic            sel_req,
  input  logic            rx_pin,
  input  logic            rx_en,
  input  logic [1:0]      rx_mode,
  output logic            rx_level,
  output logic            rx_req
);
  localparam logic [CW-1:0] FIX_T = CW'(FIX_THR);

  logic [NFIX-1:0] fix_sync;
  logic            sel_sync;
  logic            rx_sync;
  logic [CW-1:0]   sel_thr;
  logic [CW-1:0]   rx_thr;

  assign sel_thr = sel_threshold(sel_short);
  assign rx_thr  = rx_threshold(rx_mode);

  for (genvar i = 0; i < NFIX; i++) begin : g_fix
    nc_channel #(.CW(CW), .RST_LVL(RST_LVL), .THR_RST(FIX_T)) u_ch (
      .clk(clk), .rst_n(rst_n), .pin(fix_pin[i]), .en(fix_en[i]),
      .fall(1'b1), .thr(FIX_T), .sync(fix_sync[i]),
      .level(fix_level[i]), .req(fix_req[i])
    );
  end

  nc_channel #(.CW(CW), .RST_LVL(RST_LVL), .THR_RST(CW'(SEL_LONG))) u_sel (
    .clk(clk), .rst_n(rst_n), .pin(sel_pin), .en(sel_en),
    .fall(sel_fall), .thr(sel_thr), .sync(sel_sync),
    .level(sel_level), .req(sel_req)
  );

  nc_channel #(.CW(CW), .RST_LVL(RST_LVL), .THR_RST(CW'(1))) u_rx (
    .clk(clk), .rst_n(rst_n), .pin(rx_pin), .en(rx_en),
    .fall(1'b1), .thr(rx_thr), .sync(rx_sync),
    .level(rx_level), .req(rx_req)
  );
endmodule

// File: rtl/nc_checker.sv
module nc_checker #(
  parameter int NFIX = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NFIX-1:0] fix_en,
  input logic [NFIX-1:0] fix_sync,
  input logic [NFIX-1:0] fix_level,
  input logic [NFIX-1:0] fix_req,
  input logic            sel_en,
  input logic            sel_fall,
  input logic            sel_level,
  input logic            sel_req,
  input logic            rx_en,
  input logic            rx_sync,
  input logic            rx_level,
  input logic            rx_req
);
  for (genvar i = 0; i < NFIX; i++) begin : g_fix_chk
    // R4
    fix_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fix_req[i] |-> $fell(fix_level[i]));
    // R8
    fix_enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fix_req[i] |-> $past(fix_en[i]));
    // R2
    fix_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fix_level[i]) |-> ($past(fix_sync[i], 2) == $past(fix_sync[i])));
    // R10
    fix_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fix_req[i] |=> !fix_req[i]);
  end

  // R6
  sel_edge_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_req |-> (!$stable(sel_level) && (sel_level == !$past(sel_fall))));
  // R8
  sel_enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_req |-> $past(sel_en));
  // R8
  rx_enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> $past(rx_en));
  // R7
  rx_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> $fell(rx_level));
  // R10
  rx_level_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_level) |-> (rx_level == $past(rx_sync)));
  // R10
  sel_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_req |=> !sel_req);
endmodule

bind glitch_canceller nc_checker #(.NFIX(NFIX)) u_nc_checker (
  .clk(clk), .rst_n(rst_n),
  .fix_en(fix_en), .fix_sync(fix_sync), .fix_level(fix_level), .fix_req(fix_req),
  .sel_en(sel_en), .sel_fall(sel_fall), .sel_level(sel_level), .sel_req(sel_req),
  .rx_en(rx_en), .rx_sync(rx_sync), .rx_level(rx_level), .rx_req(rx_req)
);

// File: tb/glitch_canceller_test.sv
`timescale 1ns/1ps
module glitch_canceller_test;
  localparam int NFIX = 2;
  localparam int NCH  = NFIX + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NCH-1:0]  pin_v = '1;
  logic [NFIX-1:0] fix_en = '1;
  logic sel_en = 1'b1, sel_fall = 1'b1, sel_short = 1'b1;
  logic rx_en = 1'b1;
  logic [1:0] rx_mode = 2'd0;
  logic [NFIX-1:0] fix_level, fix_req;
  logic sel_level, sel_req, rx_level, rx_req;
  logic [NCH-1:0] lvl_v, req_v, req_prev;

  assign lvl_v = {rx_level, sel_level, fix_level};
  assign req_v = {rx_req, sel_req, fix_req};

  glitch_canceller #(.NFIX(NFIX)) uut (
    .clk(clk), .rst_n(rst_n),
    .fix_pin(pin_v[NFIX-1:0]), .fix_en(fix_en), .fix_level(fix_level), .fix_req(fix_req),
    .sel_pin(pin_v[NFIX]), .sel_en(sel_en), .sel_fall(sel_fall), .sel_short(sel_short),
    .sel_level(sel_level), .sel_req(sel_req),
    .rx_pin(pin_v[NFIX+1]), .rx_en(rx_en), .rx_mode(rx_mode),
    .rx_level(rx_level), .rx_req(rx_req)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  string cur_tag = "R1";
  int q_chan[$];
  int q_cyc[$];
  string q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp, input string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a request shows up
  always @(negedge clk) begin
    if (rst_n) begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (req_v[ch]) begin
          if (req_prev[ch])
            check(1'b0, "R10", 1, 0, $sformatf("request on channel %0d held two clocks", ch));
          if (q_chan.size() == 0) begin
            check(1'b0, cur_tag, ch, -1, "unexpected request on channel");
          end else begin
            int ec, ey;
            string et;
            ec = q_chan.pop_front();
            ey = q_cyc.pop_front();
            et = q_tag.pop_front();
            check(ec == ch, et, ch, ec, "request channel");
            check(ey == cyc, {et, "/R10"}, cyc, ey, "request clock");
          end
        end
      end
    end
    req_prev <= req_v;
  end

  // Driver: holds a channel's pin away from idle for len clocks
  task automatic pulse(input int ch, input int len, input int thr, input bit exp_req,
                       input bit on_ret, input string tag);
    int c;
    logic idle;
    @(negedge clk);
    c = cyc;
    idle = pin_v[ch];
    cur_tag = tag;
    if (exp_req) begin
      q_chan.push_back(ch);
      q_cyc.push_back(on_ret ? c + len + thr + 2 : c + thr + 2);
      q_tag.push_back(tag);
    end
    pin_v[ch] = !idle;
    repeat (len) @(negedge clk);
    pin_v[ch] = idle;
    repeat (2) @(negedge clk);
    check(lvl_v[ch] == ((len >= thr) ? !idle : idle), tag, int'(lvl_v[ch]),
          int'((len >= thr) ? !idle : idle), $sformatf("level after %0d-clock pulse", len));
    repeat (thr + 6) @(negedge clk);
    check(lvl_v[ch] == idle, tag, int'(lvl_v[ch]), int'(idle), "level back at idle");
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0, "run did not finish");
    finish_run();
  end

  initial begin
    req_prev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(lvl_v == '1, "R1", int'(lvl_v), int'({NCH{1'b1}}), "reset levels");
    check(req_v == '0, "R1", int'(req_v), 0, "reset requests");

    // Fixed channel thresholds and falling-only requests
    pulse(0, 1, 4, 0, 0, "R2");
    pulse(0, 3, 4, 0, 0, "R2");
    pulse(0, 4, 4, 1, 0, "R2");
    pulse(0, 7, 4, 1, 0, "R2");
    pulse(1, 9, 4, 1, 0, "R4");

    // Fragmented pulse: count restarts on each return to high
    begin
      @(negedge clk);
      cur_tag = "R3";
      pin_v[0] = 1'b0; repeat (3) @(negedge clk);
      pin_v[0] = 1'b1; @(negedge clk);
      pin_v[0] = 1'b0; repeat (3) @(negedge clk);
      pin_v[0] = 1'b1;
      check(fix_level[0] == 1'b1, "R3", int'(fix_level[0]), 1, "level during fragments");
      repeat (4) @(negedge clk);
      check(fix_level[0] == 1'b1, "R3", int'(fix_level[0]), 1, "level after fragments");
    end

    // Enable low: level follows, no request
    fix_en[1] = 1'b0;
    pulse(1, 10, 4, 0, 0, "R8");
    fix_en[1] = 1'b1;

    // Selectable channel thresholds
    sel_short = 1'b1; sel_fall = 1'b1;
    pulse(2, 14, 15, 0, 0, "R5");
    pulse(2, 15, 15, 1, 0, "R5");
    sel_short = 1'b0;
    pulse(2, 62, 63, 0, 0, "R5");
    pulse(2, 63, 63, 1, 0, "R5");

    // Rising edge select: request on the return to high
    sel_short = 1'b1; sel_fall = 1'b0;
    pulse(2, 20, 15, 1, 1, "R6");
    sel_fall = 1'b1;

    // Receive channel modes
    rx_mode = 2'd0;
    pulse(3, 1, 1, 1, 0, "R7");
    rx_mode = 2'd1;
    pulse(3, 30, 31, 0, 0, "R7");
    pulse(3, 31, 31, 1, 0, "R7");
    rx_mode = 2'd2;
    pulse(3, 62, 63, 0, 0, "R7");
    pulse(3, 63, 63, 1, 0, "R7");

    // Threshold change governs the very next pulse
    @(negedge clk);
    rx_mode = 2'd3;
    pulse(3, 126, 127, 0, 0, "R9");
    pulse(3, 127, 127, 1, 0, "R9");
    rx_mode = 2'd0;
    pulse(3, 2, 1, 1, 0, "R9");

    // Receive enable low
    rx_en = 1'b0;
    pulse(3, 5, 1, 0, 0, "R8");
    rx_en = 1'b1;

    repeat (5) @(negedge clk);
    check(q_chan.size() == 0, "R10", q_chan.size(), 0, "requests still missing");
    finish_run();
  end
endmodule